// File: doc/BRIEF.md
# Flash Block Protection Manager

This block holds the write-protection state of every erase block in a flash array and decides whether each program or erase request may start. Each block carries two status bits: a locked bit and a sticky lock-down bit. Lock, unlock and lock-down commands each name one block. Their effect on a locked-down block depends on the level of the write-protect pin. When the protection check passes, the block grants the request. It samples the program-voltage-good level once, when the request is taken. After that, the operation stays in progress until the array side reports completion. A voltage drop part way through does not end it.

Software-visible status for any one block comes out on a registered read port. Two sticky error flags record denials. One is for a protected block and one is for missing program voltage. The reset pin asserts asynchronously and is released through a two-stage synchronizer. While reset is held, every output is inactive. After release, all blocks come up locked and no block is locked down.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset release (internal reset ends on the second clock edge after `rst_n` rises), every block reads back status `2'b01`. Bit 0 is locked and bit 1 is locked-down.
- R2: A lock command (`cmd_op` = 0) or unlock command (`cmd_op` = 1) changes only the locked bit of the block given by `cmd_blk`. Every other block keeps its state. Code 3 is reserved and changes nothing.
- R3: A lock-down command (`cmd_op` = 2) on a block that is not locked down sets both its locked and locked-down bits.
- R4: While `wp_n` is low, lock and unlock commands to a locked-down block leave its status unchanged.
- R5: While `wp_n` is high, lock and unlock commands to a locked-down block change its locked bit. The locked-down bit stays set.
- R6: Only a reset clears the locked-down bit. No command sequence clears it.
- R7: A request (`req_vld`) on a locked block gives a one-cycle `deny` in the cycle after the request. It also sets `err_prot`, whatever the level of `vpp_ok`.
- R8: A request on an unlocked block with `vpp_ok` high gives a one-cycle `grant` and sets `busy`. With `vpp_ok` low it gives `deny` and sets `err_vpp`. `grant` and `deny` are never high together.
- R9: `busy` stays high until `op_done`, whatever `vpp_ok` does. Requests made while `busy` is high give neither grant nor deny.
- R10: While `rst_n` is low, `grant`, `deny`, `busy`, `err_prot`, `err_vpp` and `rd_stat` are all 0.
- R11: `err_clr` clears both error flags. A flag being set in the same cycle wins over the clear.
- R12: `rd_stat` shows the status of block `rd_blk` as it stood before the clock edge that registers it. It is valid one cycle after `rd_blk` is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous assert |
| wp_n | input | 1 | Write-protect level; low freezes locked-down blocks |
| cmd_vld | input | 1 | Protection command strobe |
| cmd_op | input | 2 | 0 lock, 1 unlock, 2 lock-down, 3 reserved |
| cmd_blk | input | IDX_W | Block addressed by the command |
| req_vld | input | 1 | Program or erase request strobe |
| req_blk | input | IDX_W | Block addressed by the request |
| vpp_ok | input | 1 | Program voltage present, sampled when a request is taken |
| op_done | input | 1 | Array reports that the running operation finished |
| err_clr | input | 1 | Clears the sticky error flags |
| rd_blk | input | IDX_W | Block whose status is read |
| grant | output | 1 | Request may start (one-cycle pulse) |
| deny | output | 1 | Request refused (one-cycle pulse) |
| busy | output | 1 | A granted operation is in progress |
| err_prot | output | 1 | Sticky: a request hit a locked block |
| err_vpp | output | 1 | Sticky: a request lacked program voltage |
| rd_stat | output | 2 | Status of `rd_blk`: bit 1 locked-down, bit 0 locked |

## Verification
The bench targets a locked-down block that gets an unlock command while `wp_n` is low. A design that ignores the pin would open the block, and `rd_stat` would read `2'b10` instead of `2'b11`. A second case drops `vpp_ok` during a granted operation. A design that keeps re-sampling the level would drop `busy` early. A third case sends a request while `busy` is high; a design that takes it would pulse `grant` or `deny`. The bench also checks a reset taken in the middle of a run, which must clear every locked-down bit. A same-cycle error set and clear must leave the flag set.

// File: rtl/lk_pkg.sv
package lk_pkg;

  typedef enum logic [1:0] {
    LK_CMD_LOCK   = 2'd0,
    LK_CMD_UNLOCK = 2'd1,
    LK_CMD_DOWN   = 2'd2,
    LK_CMD_RSVD   = 2'd3
  } lk_cmd_e;

  typedef struct packed {
    logic down;
    logic locked;
  } lk_stat_t;

  localparam lk_stat_t LK_STAT_RESET = '{down: 1'b0, locked: 1'b1};

endpackage

// File: rtl/lk_blk_cell.sv
module lk_blk_cell
  import lk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel,
  input  lk_cmd_e  cmd,
  input  logic     wp_n,
  output lk_stat_t stat
);

  lk_stat_t stat_nxt;
  logic     frozen;

  // A locked-down block is frozen while the protect pin is low
  assign frozen = stat.down && !wp_n;

  always_comb begin
    stat_nxt = stat;
    if (!frozen) begin
      case (cmd)
        LK_CMD_LOCK:   stat_nxt.locked = 1'b1;
        LK_CMD_UNLOCK: stat_nxt.locked = 1'b0;
        LK_CMD_DOWN: begin
          stat_nxt.locked = 1'b1;
          stat_nxt.down   = 1'b1;
        end
        default:       stat_nxt = stat;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= LK_STAT_RESET;
    end else if (sel) begin
      stat <= stat_nxt;
    end
  end

endmodule

// File: rtl/lk_req_ctrl.sv
module lk_req_ctrl #(
  parameter int NUM_BLK = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [IDX_W-1:0]   req_blk,
  input  logic               vpp_ok,
  input  logic               op_done,
  input  logic               err_clr,
  input  logic [NUM_BLK-1:0] lock_vec,
  output logic               grant,
  output logic               deny,
  output logic               busy,
  output logic               err_prot,
  output logic               err_vpp
);

  logic blk_in_range;
  logic blk_locked;
  logic take;
  logic grant_nxt, deny_nxt, busy_nxt;
  logic eprot_nxt, evpp_nxt;
  logic set_prot, set_vpp;

  assign blk_in_range = ({1'b0, req_blk} < (IDX_W+1)'(NUM_BLK));
  // An index past the last block is treated as protected
  assign blk_locked   = blk_in_range ? lock_vec[req_blk] : 1'b1;
  assign take         = req_vld && !busy;

  always_comb begin
    grant_nxt = 1'b0;
    deny_nxt  = 1'b0;
    set_prot  = 1'b0;
    set_vpp   = 1'b0;
    busy_nxt  = busy;
    if (take) begin
      if (blk_locked) begin
        deny_nxt = 1'b1;
        set_prot = 1'b1;
      end else if (!vpp_ok) begin
        deny_nxt = 1'b1;
        set_vpp  = 1'b1;
      end else begin
        grant_nxt = 1'b1;
        busy_nxt  = 1'b1;
      end
    end else if (busy && op_done) begin
      busy_nxt = 1'b0;
    end
    eprot_nxt = set_prot | (err_prot & ~err_clr);
    evpp_nxt  = set_vpp  | (err_vpp  & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant    <= 1'b0;
      deny     <= 1'b0;
      busy     <= 1'b0;
      err_prot <= 1'b0;
      err_vpp  <= 1'b0;
    end else begin
      grant    <= grant_nxt;
      deny     <= deny_nxt;
      busy     <= busy_nxt;
      err_prot <= eprot_nxt;
      err_vpp  <= evpp_nxt;
    end
  end

endmodule

// File: rtl/lk_stat_rd.sv
module lk_stat_rd #(
  parameter int NUM_BLK = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_blk,
  input  logic [NUM_BLK-1:0] lock_vec,
  input  logic [NUM_BLK-1:0] down_vec,
  output logic [1:0]         rd_stat
);

  logic       rd_ok;
  logic [1:0] rd_nxt;

  assign rd_ok  = ({1'b0, rd_blk} < (IDX_W+1)'(NUM_BLK));
  assign rd_nxt = rd_ok ? {down_vec[rd_blk], lock_vec[rd_blk]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stat <= 2'b00;
    end else begin
      rd_stat <= rd_nxt;
    end
  end

endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
  import lk_pkg::*;
#(
  parameter  int NUM_BLK = 16,
  localparam int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             cmd_vld,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic             req_vld,
  input  logic [IDX_W-1:0] req_blk,
  input  logic             vpp_ok,
  input  logic             op_done,
  input  logic             err_clr,
  input  logic [IDX_W-1:0] rd_blk,
  output logic             grant,
  output logic             deny,
  output logic             busy,
  output logic             err_prot,
  output logic             err_vpp,
  output logic [1:0]       rd_stat
);

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [NUM_BLK-1:0] lock_vec;
  logic [NUM_BLK-1:0] down_vec;
  lk_cmd_e            cmd_e;

  // Asynchronous assert, two-stage synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign cmd_e = lk_cmd_e'(cmd_op);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    lk_stat_t cell_stat;
    logic     cell_sel;
    assign cell_sel = cmd_vld && (cmd_blk == IDX_W'(g));
    lk_blk_cell u_cell (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .sel   (cell_sel),
      .cmd   (cmd_e),
      .wp_n  (wp_n),
      .stat  (cell_stat)
    );
    assign lock_vec[g] = cell_stat.locked;
    assign down_vec[g] = cell_stat.down;
  end

  lk_req_ctrl #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_vld  (req_vld),
    .req_blk  (req_blk),
    .vpp_ok   (vpp_ok),
    .op_done  (op_done),
    .err_clr  (err_clr),
    .lock_vec (lock_vec),
    .grant    (grant),
    .deny     (deny),
    .busy     (busy),
    .err_prot (err_prot),
    .err_vpp  (err_vpp)
  );

  lk_stat_rd #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_blk   (rd_blk),
    .lock_vec (lock_vec),
    .down_vec (down_vec),
    .rd_stat  (rd_stat)
  );

endmodule

// File: rtl/flash_lock_mgr_chk.sv
module flash_lock_mgr_chk #(
  parameter int NUM_BLK = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wp_n,
  input logic               cmd_vld,
  input logic [1:0]         cmd_op,
  input logic [IDX_W-1:0]   cmd_blk,
  input logic               req_vld,
  input logic [IDX_W-1:0]   req_blk,
  input logic               op_done,
  input logic               grant,
  input logic               deny,
  input logic               busy,
  input logic               err_prot,
  input logic [NUM_BLK-1:0] lock_vec,
  input logic [NUM_BLK-1:0] down_vec
);

  p_grant_deny_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  p_locked_denied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !busy && lock_vec[req_blk]) |=> (deny && err_prot && !grant));

  p_down_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~down_vec & $past(down_vec)) == '0));

  p_wp_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && cmd_vld && down_vec[cmd_blk]) |=> $stable(lock_vec));

  p_down_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 2'd2 && !down_vec[cmd_blk])
      |=> (down_vec[$past(cmd_blk)] && lock_vec[$past(cmd_blk)]));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> busy);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!grant && !deny));

endmodule

bind flash_lock_mgr flash_lock_mgr_chk #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wp_n     (wp_n),
  .cmd_vld  (cmd_vld),
  .cmd_op   (cmd_op),
  .cmd_blk  (cmd_blk),
  .req_vld  (req_vld),
  .req_blk  (req_blk),
  .op_done  (op_done),
  .grant    (grant),
  .deny     (deny),
  .busy     (busy),
  .err_prot (err_prot),
  .lock_vec (lock_vec),
  .down_vec (down_vec)
);

// File: tb/flash_lock_mgr_test.sv
module flash_lock_mgr_test;

  localparam int NB = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b0;
  logic          cmd_vld = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [IW-1:0] cmd_blk = '0;
  logic          req_vld = 1'b0;
  logic [IW-1:0] req_blk = '0;
  logic          vpp_ok = 1'b0;
  logic          op_done = 1'b0;
  logic          err_clr = 1'b0;
  logic [IW-1:0] rd_blk = '0;
  logic          grant, deny, busy, err_prot, err_vpp;
  logic [1:0]    rd_stat;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  bit m_lock [NB];
  bit m_down [NB];
  bit m_busy, m_ep, m_ev;

  always #5 clk = ~clk;

  flash_lock_mgr #(.NUM_BLK(NB)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_blk(cmd_blk), .req_vld(req_vld), .req_blk(req_blk), .vpp_ok(vpp_ok),
    .op_done(op_done), .err_clr(err_clr), .rd_blk(rd_blk), .grant(grant),
    .deny(deny), .busy(busy), .err_prot(err_prot), .err_vpp(err_vpp),
    .rd_stat(rd_stat)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < NB; i++) begin
      m_lock[i] = 1'b1;
      m_down[i] = 1'b0;
    end
    m_busy = 1'b0; m_ep = 1'b0; m_ev = 1'b0;
  endfunction

  // One clock: drive at the falling edge, check just after the rising edge
  task automatic step(string rtag, bit cv, int op, int cb, bit wp, bit rv, int rb,
                      bit vpp, bit dn, bit clr, int rd);
    bit e_g, e_d, s_p, s_v;
    string gtag;
    int e_rd;
    @(negedge clk);
    cmd_vld = cv; cmd_op = 2'(op); cmd_blk = IW'(cb); wp_n = wp;
    req_vld = rv; req_blk = IW'(rb); vpp_ok = vpp; op_done = dn;
    err_clr = clr; rd_blk = IW'(rd);
    e_rd = {m_down[rd], m_lock[rd]};
    e_g = 0; e_d = 0; s_p = 0; s_v = 0; gtag = "R9";
    if (rv && !m_busy) begin
      if (m_lock[rb]) begin e_d = 1; s_p = 1; gtag = "R7"; end
      else if (!vpp) begin e_d = 1; s_v = 1; gtag = "R8"; end
      else begin e_g = 1; gtag = "R8"; end
    end
    if (e_g) m_busy = 1;
    else if (m_busy && dn) m_busy = 0;
    m_ep = s_p | (m_ep & ~clr);
    m_ev = s_v | (m_ev & ~clr);
    if (cv && !(m_down[cb] && !wp)) begin
      case (op)
        0: m_lock[cb] = 1;
        1: m_lock[cb] = 0;
        2: begin m_lock[cb] = 1; m_down[cb] = 1; end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk(gtag, "grant", grant, e_g);
    chk(gtag, "deny", deny, e_d);
    chk("R9", "busy", busy, m_busy);
    chk(clr ? "R11" : "R7", "err_prot", err_prot, m_ep);
    chk(clr ? "R11" : "R8", "err_vpp", err_vpp, m_ev);
    chk(rtag, "rd_stat", rd_stat, e_rd);
  endtask

  task automatic idle(int rd);
    step("R12", 0, 0, 0, 0, 0, 0, 1, 0, 0, rd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R10", "grant in reset", grant, 0);
    chk("R10", "deny in reset", deny, 0);
    chk("R10", "busy in reset", busy, 0);
    chk("R10", "errors in reset", {err_prot, err_vpp}, 0);
    chk("R10", "rd_stat in reset", rd_stat, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(posedge clk); @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R1: every block comes up locked, not locked down
    for (int i = 0; i <= NB; i++) step("R1", 0, 0, 0, 1, 0, 0, 1, 0, 0, i % NB);
    // R7: request on locked block 2
    step("R7", 0, 0, 0, 1, 1, 2, 1, 0, 0, 2);
    // R2: unlock block 2, neighbours unchanged
    step("R2", 1, 1, 2, 0, 0, 0, 1, 0, 0, 2);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 0, 0, 2);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 0, 0, 3);
    step("R2", 1, 3, 2, 0, 0, 0, 1, 0, 0, 1);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 0, 0, 2);
    // R8: no program voltage, then a grant
    step("R8", 0, 0, 0, 0, 1, 2, 0, 0, 0, 2);
    step("R8", 0, 0, 0, 0, 1, 2, 1, 0, 0, 2);
    // R9: voltage drops and new requests while busy
    step("R9", 0, 0, 0, 0, 1, 2, 0, 0, 0, 2);
    step("R9", 0, 0, 0, 0, 1, 4, 0, 0, 0, 2);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0, 2);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
    // R11: set wins over clear, then clear
    step("R11", 0, 0, 0, 0, 1, 9, 1, 0, 1, 9);
    step("R11", 0, 0, 0, 0, 0, 0, 1, 0, 1, 9);
    // R3: lock-down block 5
    step("R3", 1, 2, 5, 0, 0, 0, 1, 0, 0, 5);
    step("R3", 0, 0, 0, 0, 0, 0, 1, 0, 0, 5);
    // R4: unlock ignored while pin low
    step("R4", 1, 1, 5, 0, 0, 0, 1, 0, 0, 5);
    step("R4", 0, 0, 0, 0, 1, 5, 1, 0, 0, 5);
    // R5: pin high, unlock allowed, lock-down stays
    step("R5", 1, 1, 5, 1, 0, 0, 1, 0, 0, 5);
    step("R5", 0, 0, 0, 1, 1, 5, 1, 0, 0, 5);
    step("R5", 0, 0, 0, 1, 0, 0, 1, 1, 0, 5);
    step("R5", 1, 0, 5, 1, 0, 0, 1, 0, 0, 5);
    step("R5", 0, 0, 0, 1, 0, 0, 1, 0, 0, 5);
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      int p = $urandom_range(99);
      step("R12", p < 40, $urandom_range(3), $urandom_range(NB-1), $urandom_range(1),
           p >= 40 && p < 70, $urandom_range(NB-1), $urandom_range(9) != 0,
           $urandom_range(4) == 0, $urandom_range(19) == 0, $urandom_range(NB-1));
    end
    // R6: lock-down cleared only by reset
    for (int i = 0; i < NB; i++) step("R6", 1, 2, i, 1, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < NB; i++) step("R6", 1, 1, i, 1, 0, 0, 1, 1, 0, i);
    do_reset();
    for (int i = 0; i <= NB; i++) step("R6", 0, 0, 0, 0, 0, 0, 1, 0, 0, i % NB);
    idle(0);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule